// File: doc/BRIEF.md
# DMA Test-Control Register with Stepping Strobes

This block is an 8-bit memory-mapped test register for a DMA engine. It lets software walk the DMA address pointer and the remaining byte count forward by hand, choose which FIFO depth the byte-residue logic should assume, and drive the internal DMA write-direction signal. The direction signal is not written directly. A stored master bit decides whether a write to the direction bit sets the signal or clears it.

The block also holds the 32-bit DMA address pointer and the 24-bit byte counter. Software loads both one byte at a time through the same register bus. Two strobe bits in the control byte move them one step at a time. A step covers the bytes left up to the next 4-byte boundary, and never more than the bytes still counted. The control byte also carries three plain storage bits: one burst-length bit and the two upper bits of a byte offset. These are driven out unchanged.

All register writes and counter updates happen on one clock edge. Reset is synchronous and active high. Reads are combinational from the selected offset.

Top module: `dma_testctl`

## Requirements
- R1: While `rst` is high, the address pointer, the byte counter, the direction signal, the master bit and the depth select all clear on each clock edge. After reset, control bits 7..3 read 0 and `fifo_depth` is 88.
- R2: Offsets 4..7 hold the address pointer, one byte each, least significant byte at offset 4. Offsets 8..10 hold the byte counter in the same order. A write stores the byte at the next edge, and a read returns it.
- R3: Writing 1 to control bit 7 (offset 0) adds a step to the address pointer at that edge. The step is the smaller of (4 minus the address's two low bits) and the current byte count.
- R4: Writing 1 to control bit 6 subtracts the same step, computed the same way, from the byte counter at that edge.
- R5: When the byte counter is 0, the step is 0, and neither strobe changes the pointer or the counter.
- R6: When bits 7 and 6 are written as 1 together, both updates use the pre-write pointer and count, and both take effect at the same edge. The pointer grows by exactly the amount the counter shrinks.
- R7: Control bit 5 selects the reported depth: 0 gives `fifo_depth` = 88 and 1 gives 536. The bit reads back as written.
- R8: Control bit 4 is a stored master bit. Writing 1 to control bit 3 makes `dma_wr_dir` equal to the master bit. Writing 0 to bit 3 leaves `dma_wr_dir` unchanged. Bit 3 reads back the current `dma_wr_dir`.
- R9: If a single write changes bit 4 and also sets bit 3, the master value held before that write decides the direction.
- R10: Control bits 7 and 6 always read 0.
- R11: Control bits 2..0 are plain storage. Bit 2 drives `burst_sel`, bits 1..0 drive `offset_hi`, and all three read back as written.
- R12: Offsets other than 0, 4..7 and 8..10 read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe for the selected offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `reg_addr` |
| dma_addr | output | 32 | DMA address pointer |
| byte_cnt | output | 24 | Remaining byte count |
| dma_wr_dir | output | 1 | Internal DMA write-direction signal |
| fifo_depth | output | 11 | Effective FIFO depth (88 or 536) |
| burst_sel | output | 1 | Stored burst-length bit |
| offset_hi | output | 2 | Stored upper offset bits |

## Verification
Two pairs of effects can land on the same edge.

The first pair is the address step and the count decrement. The bench writes 0xC0 from several start points: a misaligned address with a large count, an aligned address with a count below four, and a count of zero. It then checks that the pointer rose by exactly the amount the count fell, using the values held before the write.

The second pair is a master-bit change and a direction write in the same byte. The bench writes 0x18 and 0x08 in turn and expects the direction to follow the master value from the previous write.

// File: rtl/dma_testctl.sv
module dma_testctl #(
  parameter int REG_AW      = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int WORD_BYTES  = 4,
  parameter int DEPTH_W     = 11,
  parameter int DEPTH_SMALL = 88,
  parameter int DEPTH_BIG   = 536,
  parameter int CTL_OFS     = 0,
  parameter int ADDR_OFS    = 4,
  parameter int CNT_OFS     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic [ADDR_W-1:0]  dma_addr,
  output logic [CNT_W-1:0]   byte_cnt,
  output logic               dma_wr_dir,
  output logic [DEPTH_W-1:0] fifo_depth,
  output logic               burst_sel,
  output logic [1:0]         offset_hi
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_BYTES  = CNT_W / 8;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              big_q, master_q, dir_q;
  logic [2:0]        low_q;
  logic [LANE_W:0]   room, step;
  logic              ctl_wr;

  assign ctl_wr = wr_en && (reg_addr == REG_AW'(CTL_OFS));
  assign room   = (LANE_W+1)'(WORD_BYTES) - {1'b0, addr_q[LANE_W-1:0]};
  assign step   = (cnt_q < CNT_W'(room)) ? cnt_q[LANE_W:0] : room;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      big_q    <= 1'b0;
      master_q <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        if (wr_data[7]) addr_q <= addr_q + ADDR_W'(step);
        if (wr_data[6]) cnt_q  <= cnt_q - CNT_W'(step);
        if (wr_data[3]) dir_q  <= master_q;
        big_q    <= wr_data[5];
        master_q <= wr_data[4];
      end
      for (int i = 0; i < ADDR_BYTES; i++)
        if (wr_en && reg_addr == REG_AW'(ADDR_OFS + i)) addr_q[8*i +: 8] <= wr_data;
      for (int i = 0; i < CNT_BYTES; i++)
        if (wr_en && reg_addr == REG_AW'(CNT_OFS + i)) cnt_q[8*i +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk)
    if (ctl_wr) low_q <= wr_data[2:0];

  always_comb begin
    rd_data = '0;
    if (reg_addr == REG_AW'(CTL_OFS)) rd_data = {2'b00, big_q, master_q, dir_q, low_q};
    for (int i = 0; i < ADDR_BYTES; i++)
      if (reg_addr == REG_AW'(ADDR_OFS + i)) rd_data = addr_q[8*i +: 8];
    for (int i = 0; i < CNT_BYTES; i++)
      if (reg_addr == REG_AW'(CNT_OFS + i)) rd_data = cnt_q[8*i +: 8];
  end

  assign dma_addr   = addr_q;
  assign byte_cnt   = cnt_q;
  assign dma_wr_dir = dir_q;
  assign fifo_depth = big_q ? DEPTH_W'(DEPTH_BIG) : DEPTH_W'(DEPTH_SMALL);
  assign burst_sel  = low_q[2];
  assign offset_hi  = low_q[1:0];
endmodule

// File: rtl/dma_testctl_chk.sv
module dma_testctl_chk #(
  parameter int REG_AW      = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int DEPTH_W     = 11,
  parameter int DEPTH_SMALL = 88,
  parameter int DEPTH_BIG   = 536,
  parameter int CTL_OFS     = 0
) (
  input logic               clk,
  input logic               rst,
  input logic [REG_AW-1:0]  reg_addr,
  input logic               wr_en,
  input logic [7:0]         wr_data,
  input logic [ADDR_W-1:0]  dma_addr,
  input logic [CNT_W-1:0]   byte_cnt,
  input logic               dma_wr_dir,
  input logic [DEPTH_W-1:0] fifo_depth,
  input logic               master_q
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (reg_addr == REG_AW'(CTL_OFS));

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!dma_wr_dir && dma_addr == '0 && byte_cnt == '0 && fifo_depth == DEPTH_W'(DEPTH_SMALL))); // R1

  AST_ADDR_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[7] && byte_cnt != '0) |=>
      ((dma_addr - $past(dma_addr)) >= ADDR_W'(1) && (dma_addr - $past(dma_addr)) <= ADDR_W'(4))); // R3

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[6]) |=> (byte_cnt <= $past(byte_cnt))); // R4

  AST_ZERO_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && byte_cnt == '0) |=> ($stable(dma_addr) && $stable(byte_cnt))); // R5

  AST_PAIRED_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[7] && wr_data[6]) |=>
      ((dma_addr - $past(dma_addr)) == ADDR_W'($past(byte_cnt) - byte_cnt))); // R6

  AST_DEPTH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (fifo_depth == ($past(wr_data[5]) ? DEPTH_W'(DEPTH_BIG) : DEPTH_W'(DEPTH_SMALL)))); // R7

  AST_DIR_FROM_OLD_MASTER: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[3]) |=> (dma_wr_dir == $past(master_q))); // R9

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && wr_data[3]) |=> $stable(dma_wr_dir)); // R8
endmodule

bind dma_testctl dma_testctl_chk #(
  .REG_AW(REG_AW), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH_W(DEPTH_W),
  .DEPTH_SMALL(DEPTH_SMALL), .DEPTH_BIG(DEPTH_BIG), .CTL_OFS(CTL_OFS)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
  .dma_addr(dma_addr), .byte_cnt(byte_cnt), .dma_wr_dir(dma_wr_dir),
  .fifo_depth(fifo_depth), .master_q(master_q)
);

// File: tb/sim_dma_testctl.sv
`timescale 1ns/1ps
module sim_dma_testctl;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  logic [31:0] dma_addr;
  logic [23:0] byte_cnt;
  logic        dma_wr_dir, burst_sel;
  logic [10:0] fifo_depth;
  logic [1:0]  offset_hi;

  dma_testctl u0 (.clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .dma_addr(dma_addr), .byte_cnt(byte_cnt),
    .dma_wr_dir(dma_wr_dir), .fifo_depth(fifo_depth), .burst_sel(burst_sel),
    .offset_hi(offset_hi));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  longint m_addr, m_cnt;
  bit m_big, m_master, m_dir, m_known;
  int m_low;

  function automatic int exp_rd(input int a);
    if (a == 0) return (m_big << 5) | (m_master << 4) | (m_dir << 3) | (m_known ? m_low : 0);
    if (a >= 4 && a <= 7) return int'((m_addr >> (8*(a-4))) & 255);
    if (a >= 8 && a <= 10) return int'((m_cnt >> (8*(a-8))) & 255);
    return 0;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int r;
    r = int'(rd_data);
    if (reg_addr == 0 && !m_known) r = r & 8'hF8;
    chk({tag, " rd_data"}, r, exp_rd(int'(reg_addr)));
    chk({tag, " dma_addr"}, dma_addr, m_addr);
    chk({tag, " byte_cnt"}, byte_cnt, m_cnt);
    chk({tag, " dma_wr_dir"}, dma_wr_dir, m_dir);
    chk({tag, " fifo_depth"}, fifo_depth, m_big ? 536 : 88);
    if (m_known) chk({tag, " low bits"}, {burst_sel, offset_hi}, m_low);
  endtask

  task automatic model_step(input int a, input bit we, input int d);
    longint room, st;
    if (!we) return;
    if (a == 0) begin
      room = 4 - (m_addr & 3);
      st = (m_cnt < room) ? m_cnt : room;
      if (d[7]) m_addr = (m_addr + st) & 64'hFFFF_FFFF;
      if (d[6]) m_cnt = m_cnt - st;
      if (d[3]) m_dir = m_master;
      m_master = d[4];
      m_big = d[5];
      m_low = d & 7;
      m_known = 1;
    end else if (a >= 4 && a <= 7) begin
      m_addr = (m_addr & ~(64'hFF << (8*(a-4)))) | (longint'(d) << (8*(a-4)));
    end else if (a >= 8 && a <= 10) begin
      m_cnt = (m_cnt & ~(64'hFF << (8*(a-8)))) | (longint'(d) << (8*(a-8)));
    end
  endtask

  task automatic cyc(input int a, input bit we, input int d, input string tag);
    @(negedge clk);
    reg_addr = 4'(a); wr_en = we; wr_data = 8'(d);
    #1 compare(tag);
    @(posedge clk);
    model_step(a, we, d);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(a, 1'b0, 0, tag);
  endtask

  task automatic load(input longint ad, input longint cn, input string tag);
    for (int i = 0; i < 4; i++) cyc(4 + i, 1'b1, int'((ad >> (8*i)) & 255), tag);
    for (int i = 0; i < 3; i++) cyc(8 + i, 1'b1, int'((cn >> (8*i)) & 255), tag);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_addr = 0; m_cnt = 0; m_big = 0; m_master = 0; m_dir = 0; m_low = 0; m_known = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    rd(0, "R1"); rd(4, "R1"); rd(8, "R1");
    // R2: bytewise load and readback
    load(64'h1000_0001, 64'h10, "R2");
    for (int i = 4; i <= 10; i++) rd(i, "R2");
    // R3: misaligned address, step 3
    cyc(0, 1'b1, 8'h80, "R3"); rd(4, "R3");
    // R4: aligned address, step 4
    cyc(0, 1'b1, 8'h40, "R4"); rd(8, "R4");
    // R6: both strobes, address low bits 2
    load(64'h2000_0002, 64'h100, "R6");
    cyc(0, 1'b1, 8'hC0, "R6"); rd(4, "R6"); rd(8, "R6");
    // R6: count below room
    load(64'h3000_0000, 64'h1, "R6");
    cyc(0, 1'b1, 8'hC0, "R6"); rd(8, "R6");
    // R5: count zero, no change
    cyc(0, 1'b1, 8'hC0, "R5"); rd(4, "R5"); rd(8, "R5");
    // R3: address wrap at top
    load(64'hFFFF_FFFF, 64'h5, "R3");
    cyc(0, 1'b1, 8'hC0, "R3"); rd(4, "R3"); rd(7, "R3");
    // R7: depth select both ways
    cyc(0, 1'b1, 8'h20, "R7"); rd(0, "R7");
    cyc(0, 1'b1, 8'h00, "R7"); rd(0, "R7");
    // R9: master set and bit 3 in one write, old master 0 governs
    cyc(0, 1'b1, 8'h18, "R9"); rd(0, "R9");
    // R8: master now 1, bit 3 asserts
    cyc(0, 1'b1, 8'h18, "R8"); rd(0, "R8");
    // R8: bit 3 written 0 has no effect
    cyc(0, 1'b1, 8'h10, "R8"); rd(0, "R8");
    // R9: master cleared with bit 3, old master 1 keeps dir high
    cyc(0, 1'b1, 8'h08, "R9"); rd(0, "R9");
    cyc(0, 1'b1, 8'h08, "R8"); rd(0, "R8");
    // R10: strobes read 0
    load(64'h40, 64'h40, "R10");
    cyc(0, 1'b1, 8'hC5, "R10"); rd(0, "R10");
    // R11: low storage bits
    cyc(0, 1'b1, 8'h06, "R11"); rd(0, "R11");
    cyc(0, 1'b1, 8'h01, "R11"); rd(0, "R11");
    // R12: unmapped offsets
    cyc(3, 1'b1, 8'hFF, "R12"); rd(3, "R12");
    cyc(15, 1'b1, 8'hA5, "R12"); rd(15, "R12"); rd(11, "R12");
    rd(0, "R12"); rd(4, "R12"); rd(8, "R12");
    // R1: reset mid-run
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    m_addr = 0; m_cnt = 0; m_big = 0; m_master = 0; m_dir = 0;
    @(negedge clk) rst = 1'b0;
    rd(0, "R1"); rd(5, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule